// File: doc/BRIEF.md
# Floating-point exception flag and trap controller

This block follows a floating-point datapath. When an operation completes, the datapath presents five raw exception indications on a single-cycle strobe: invalid, divide-by-zero, overflow, underflow and inexact. The block holds a 32-bit control word that contains an enable byte and a sticky-flag byte. It compares each operation's indications against the enable byte. For each operation it does one of two things: it raises a one-cycle trap request with an 8-bit code, or it merges the non-trapping conditions into the sticky flags.

The decision runs in two passes. The first pass covers the conditions other than inexact. If any of them is enabled, the trap code reports every present condition, inexact included. Inexact is handled on its own in the second pass, which runs only when the first pass did not trap. An inexact trap reports inexact alone.

Tininess without an inexact result is discarded unless underflow is enabled. Software reads and writes the control word through a plain word-wide port.

Top module: `fp_trap_ctrl`

## Requirements
- R1: During and after reset the control word reads 0x00000000 and trap_req is low.
- R2: A cycle with ctl_wr_en high loads the whole word from ctl_wr_data, and ctl_rd_data shows it from the next cycle. Without a write, the enable byte (bits 31:24) and bits 15:0 hold their value.
- R3: An operation strobe whose op_exc is zero causes no trap and leaves the control word unchanged.
- R4: The underflow indication (op_exc[1]) is discarded when inexact (op_exc[0]) is absent and the underflow enable (bit 28) is clear.
- R5: op_exc is ordered invalid[4], divide-by-zero[3], overflow[2], underflow[1], inexact[0]. The enables are bits 31, 30, 29, 28 and 27 in that order. If a present non-inexact condition is enabled, trap_req pulses in the cycle after the strobe. The code then has invalid 0x80, divide-by-zero 0x40, overflow 0x20, underflow 0x10 and inexact 0x08 set for every present condition. No sticky flag changes for that operation.
- R6: When the first pass does not trap, the present non-inexact conditions are ORed into flag bits 23, 22, 21 and 20.
- R7: Inexact with no first-pass trap either traps with code exactly 0x08, when bit 27 is set, or sets flag bit 19.
- R8: Trap code bits 2:0 are always zero. Bit 2 would mark an incremented inexact result, so every inexact result is reported as truncated.
- R9: trap_req is high for exactly one cycle per trapping operation and never follows a cycle without a strobe.
- R10: Operations only set sticky flags and never clear them. When a write and a strobe share a cycle, the decision uses the enable byte held before the write, and the operation's flags are ORed onto the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe marking a completed operation |
| op_exc | input | 5 | Raw indications {invalid, div-by-zero, overflow, underflow, inexact} |
| ctl_wr_en | input | 1 | Control word write enable |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_rd_data | output | 32 | Current control word |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 8 | Exception code that goes with trap_req |

## Verification
The bench builds the block with its default geometry: a 32-bit control word, the enable byte at bit 24 and the flag byte at bit 16. These are the positions software sees, and every expected code and flag value is derived from them. Directed sequences cover tininess filtering, first-pass codes that carry inexact along, second-pass inexact traps that leave overflow in the flags, and a write landing in the same cycle as a strobe. A long random run then mixes enables, raw patterns and writes against the cycle model.

// File: rtl/fptc_pkg.sv
package fptc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NX_N   = 4;   // conditions handled in the first pass
  localparam int unsigned EXC_W  = NX_N + 1;

  // bit positions inside an enable, flag or code byte
  localparam int unsigned POS_INV = 7;
  localparam int unsigned POS_DZ  = 6;
  localparam int unsigned POS_OVF = 5;
  localparam int unsigned POS_UNF = 4;
  localparam int unsigned POS_INX = 3;

  typedef struct packed {
    logic inv;
    logic dz;
    logic ovf;
    logic unf;
    logic inx;
  } exc_t;
endpackage

// File: rtl/fptc_filter.sv
module fptc_filter
  import fptc_pkg::*;
(
  input  exc_t              raw,
  input  logic [BYTE_W-1:0] enable,
  output logic              trap_hit,
  output logic [BYTE_W-1:0] trap_code,
  output logic [BYTE_W-1:0] flag_set
);
  localparam int unsigned LOW_PAD = POS_INX;

  logic            unf_kept;
  logic [NX_N-1:0] nx;
  logic [NX_N-1:0] nx_en;
  logic            pass1_trap;
  logic            inx_trap;

  // tininess survives only with an inexact result or an enabled underflow
  assign unf_kept = raw.unf & (raw.inx | enable[POS_UNF]);
  assign nx       = {raw.inv, raw.dz, raw.ovf, unf_kept};

  for (genvar g = 0; g < NX_N; g++) begin : g_en
    assign nx_en[g] = nx[g] & enable[POS_UNF + g];
  end

  assign pass1_trap = |nx_en;
  assign inx_trap   = ~pass1_trap & raw.inx & enable[POS_INX];
  assign trap_hit   = pass1_trap | inx_trap;

  always_comb begin
    trap_code = '0;
    flag_set  = '0;
    if (pass1_trap) begin
      trap_code = {nx, raw.inx, {LOW_PAD{1'b0}}};
    end else begin
      flag_set = {nx, raw.inx & ~enable[POS_INX], {LOW_PAD{1'b0}}};
      if (inx_trap) begin
        trap_code[POS_INX] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fptc_ctl_reg.sv
module fptc_ctl_reg #(
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned FLAG_LSB = 16,
  parameter int unsigned FLAG_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic [FLAG_W-1:0] flag_set,
  output logic [CTL_W-1:0]  q
);
  logic [CTL_W-1:0] base;
  logic [CTL_W-1:0] d;
  logic             upd;

  always_comb begin
    base = wr_en ? wr_data : q;
    d    = base | (CTL_W'(flag_set) << FLAG_LSB);
    upd  = wr_en | (|flag_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= d;
    end
  end
endmodule

// File: rtl/fptc_trap_out.sv
module fptc_trap_out #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [CODE_W-1:0] code,
  output logic              req,
  output logic [CODE_W-1:0] req_code
);
  logic              req_d;
  logic [CODE_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    req_d   = hit;
    code_en = hit | req;
    code_d  = hit ? code : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_code <= '0;
    end else if (code_en) begin
      req_code <= code_d;
    end
  end
endmodule

// File: rtl/fp_trap_ctrl.sv
module fp_trap_ctrl
  import fptc_pkg::*;
#(
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned MASK_LSB = 24,
  parameter int unsigned FLAG_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       op_exc,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  output logic             trap_req,
  output logic [7:0]       trap_code
);
  localparam int unsigned MASK_MSB = MASK_LSB + BYTE_W - 1;

  logic [CTL_W-1:0]  ctl_q;
  exc_t              raw_g;
  logic [BYTE_W-1:0] enable;
  logic              hit;
  logic [BYTE_W-1:0] code_c;
  logic [BYTE_W-1:0] flag_set;

  assign raw_g  = op_valid ? exc_t'(op_exc) : '0;
  assign enable = ctl_q[MASK_MSB:MASK_LSB];

  fptc_filter u_filter (
    .raw       (raw_g),
    .enable    (enable),
    .trap_hit  (hit),
    .trap_code (code_c),
    .flag_set  (flag_set)
  );

  fptc_ctl_reg #(
    .CTL_W    (CTL_W),
    .FLAG_LSB (FLAG_LSB),
    .FLAG_W   (BYTE_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_en),
    .wr_data  (ctl_wr_data),
    .flag_set (flag_set),
    .q        (ctl_q)
  );

  fptc_trap_out #(
    .CODE_W (BYTE_W)
  ) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .code     (code_c),
    .req      (trap_req),
    .req_code (trap_code)
  );

  assign ctl_rd_data = ctl_q;
endmodule

// File: rtl/fp_trap_ctrl_sva.sv
module fp_trap_ctrl_sva #(
  parameter int unsigned CTL_W    = 32,
  parameter int unsigned MASK_LSB = 24,
  parameter int unsigned FLAG_LSB = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [4:0]       op_exc,
  input logic             ctl_wr_en,
  input logic [CTL_W-1:0] ctl_rd_data,
  input logic             trap_req,
  input logic [7:0]       trap_code
);
  logic [7:0] flags;
  logic [7:0] ena;
  assign flags = ctl_rd_data[FLAG_LSB +: 8];
  assign ena   = ctl_rd_data[MASK_LSB +: 8];

  a_r9_no_trap_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_req);

  a_r3_zero_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_exc == 5'b0 && !ctl_wr_en) |=> (!trap_req && $stable(ctl_rd_data)));

  a_r8_truncated_code: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_code[2:0] == 3'b000));

  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> ((flags & $past(flags)) == $past(flags)));

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ena));

  a_r5_enabled_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ctl_wr_en && (|(op_exc[4:2] & ena[7:5]))) |=> (trap_req && $stable(ctl_rd_data)));
endmodule

bind fp_trap_ctrl fp_trap_ctrl_sva #(
  .CTL_W    (CTL_W),
  .MASK_LSB (MASK_LSB),
  .FLAG_LSB (FLAG_LSB)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_exc      (op_exc),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_rd_data (ctl_rd_data),
  .trap_req    (trap_req),
  .trap_code   (trap_code)
);

// File: tb/fp_trap_ctrl_tb.sv
module fp_trap_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_exc;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic [31:0] ctl_rd_data;
  logic        trap_req;
  logic [7:0]  trap_code;

  int n_run;
  int n_fail;
  bit done;
  string cur_req;

  // reference model state
  logic [31:0] m_reg;
  logic        m_trap;
  logic [7:0]  m_code;

  fp_trap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .trap_req(trap_req), .trap_code(trap_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural model, one evaluation per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_trap = 0; m_code = 0;
    end else begin
      int en, nx, fs, inx, unf;
      en = m_reg[31:24]; fs = 0; m_trap = 0; m_code = 0;
      if (op_valid) begin
        inx = op_exc[0];
        unf = op_exc[1] && (inx || en[4]);
        nx  = op_exc[4]*128 + op_exc[3]*64 + op_exc[2]*32 + unf*16;
        if ((nx & en) != 0) begin
          m_trap = 1; m_code = 8'(nx + inx*8);
        end else begin
          fs = nx;
          if (inx != 0) begin
            if (en[3]) begin m_trap = 1; m_code = 8'h08; end
            else fs = fs | 8;
          end
        end
      end
      if (ctl_wr_en) m_reg = ctl_wr_data;
      m_reg[23:16] = m_reg[23:16] | 8'(fs);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk({cur_req, " trap_req"},  {31'b0, trap_req}, {31'b0, m_trap});
    chk({cur_req, " trap_code"}, {24'b0, trap_code}, {24'b0, m_code});
    chk({cur_req, " ctl_word"},  ctl_rd_data, m_reg);
  endtask

  task automatic drive(logic v, logic [4:0] e, logic w, logic [31:0] wd);
    @(negedge clk);
    cmp_all();
    op_valid = v; op_exc = e; ctl_wr_en = w; ctl_wr_data = wd;
  endtask

  task automatic idle(); drive(0, 0, 0, 0); endtask
  task automatic op(logic [4:0] e); drive(1, e, 0, 0); idle(); endtask
  task automatic wr(logic [31:0] v); drive(0, 0, 1, v); idle(); endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0; cur_req = "R1";
    rst_n = 0; op_valid = 0; op_exc = 0; ctl_wr_en = 0; ctl_wr_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", ctl_rd_data, 0);
    chk("R1 reset trap", {31'b0, trap_req}, 0);
    rst_n = 1;
    idle();

    cur_req = "R2";
    wr(32'h1234_5678);
    chk("R2 readback", ctl_rd_data, 32'h1234_5678);
    wr(32'h0);

    cur_req = "R3";
    op(5'b00000);
    chk("R3 zero no trap", {31'b0, trap_req}, 0);

    cur_req = "R4";
    op(5'b00010);                       // lone tininess, disabled: dropped
    chk("R4 dropped", ctl_rd_data, 0);
    op(5'b00011);                       // tininess with inexact kept
    chk("R4 kept flags", ctl_rd_data, 32'h0018_0000);
    wr(32'h1000_0000);
    op(5'b00010);                       // enabled underflow traps
    chk("R4 unf trap code", {24'b0, trap_code}, 32'h10);

    cur_req = "R5";
    wr(32'h8000_0000);
    op(5'b10000);
    chk("R5 invalid code", {24'b0, trap_code}, 32'h80);
    wr(32'h2000_0000);
    op(5'b00101);
    chk("R5 ovf carries inexact", {24'b0, trap_code}, 32'h28);
    chk("R5 flags untouched", ctl_rd_data, 32'h2000_0000);

    cur_req = "R6";
    wr(32'h0);
    op(5'b01000);
    chk("R6 dz flag", ctl_rd_data, 32'h0040_0000);

    cur_req = "R7";
    wr(32'h0800_0000);
    op(5'b00101);
    chk("R7 inexact only code", {24'b0, trap_code}, 32'h08);
    chk("R7 ovf flagged", ctl_rd_data, 32'h0820_0000);
    wr(32'h0);
    op(5'b00001);
    chk("R7 inexact flag", ctl_rd_data, 32'h0008_0000);

    cur_req = "R8";
    wr(32'hF800_0000);
    op(5'b00011);
    chk("R8 low code bits", {29'b0, trap_code[2:0]}, 0);

    cur_req = "R9";
    drive(1, 5'b10000, 0, 0);
    drive(1, 5'b01000, 0, 0);
    idle();
    chk("R9 second pulse code", {24'b0, trap_code}, 32'h40);
    idle();
    chk("R9 pulse ended", {31'b0, trap_req}, 0);

    cur_req = "R10";
    wr(32'h0000_0000);
    drive(1, 5'b00100, 1, 32'h2000_0000);   // decision uses old enables
    idle();
    chk("R10 write plus op", ctl_rd_data, 32'h2020_0000);
    chk("R10 no trap from new enable", {31'b0, trap_req}, 0);
    op(5'b00001);
    chk("R10 sticky kept", ctl_rd_data[23:16], 8'h28);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] e;
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: e = 5'b10000;
        2'd1: e = 5'b01000;
        default: e = {2'b00, r[4:2]};
      endcase
      drive(r[5], e, r[8:6] == 0, {r[31:27], 3'b0, $urandom_range(0,255) == 0 ? 8'h00 : r[23:16], 16'h0});
    end
    idle();
    idle();

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule